// File: doc/BRIEF.md
# Multi-Chip SDRAM Refresh Scheduler

This block decides when the external SDRAM devices need an auto-refresh and hands those requests to the memory controller's management arbiter. There they compete with ordinary data commands. It runs on the memory clock, so the refresh interval stays fixed when the system clock is scaled. A down-counter is loaded from a programmable period, given in memory-clock cycles. Each time the counter runs out, the block walks through the populated chip selects and presents one request per chip. Each request uses a valid/ready handshake.

A two-bit chip-count setting says how many chip selects carry devices. A value N enables chips 0 through N, so the upper chips are dropped first. A period of zero switches generation off. The refresh-enable input is held low while the controller is being configured, and no requests are raised during that time. If the counter runs out again before the previous walk has finished, the block sets a sticky overrun flag and does not begin a second walk.

Top module: `rfsh_sched`

## Requirements
- R1: After reset, `req_valid` and `overrun` are 0 and `req_chip` is 0.
- R2: With enable high and period P (P ≥ 1), loaded while enable was low, the first request appears in the cycle after the (P+1)-th rising edge after enable rises. Later walks start every P cycles.
- R3: A walk presents chip indices 0, 1, …, N in ascending order, one index per accepted handshake. `req_chip` is the binary chip number, and N is the value of `active_chips`. `req_valid` falls after the last accepted request, unless a new walk starts in that same cycle.
- R4: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_chip` keeps its value.
- R5: A period of 0 produces no requests, however long enable stays high.
- R6: While `refresh_en` is low, no request is raised. Dropping enable clears `req_valid` at the next edge.
- R7: A new period value written after a reload first takes effect at the following reload. The interval already being counted keeps the old length.
- R8: `overrun` becomes 1 and stays 1 until reset when the counter expires while a walk is still pending. In that case no second walk starts. An expiry in the same cycle as the final handshake starts the next walk without setting `overrun`.
- R9: `active_chips` is captured when a walk starts. A change during the walk affects only later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_en | input | 1 | High when refresh may be generated (low during configuration) |
| period | input | PERIOD_W | Refresh interval in memory-clock cycles; 0 disables |
| active_chips | input | CHIP_W | Highest populated chip number |
| req_valid | output | 1 | Refresh request pending |
| req_chip | output | CHIP_W | Chip select the pending request targets |
| req_ready | input | 1 | Arbiter accepts the request this cycle |
| overrun | output | 1 | Sticky: an interval expired while a walk was still pending |

## Verification
The bench measures the edge on which the first request appears, because an off-by-one reload would shift it by a cycle. It stalls the handshake and changes the chip count during the stall. A scheduler that failed to hold its index would skip a chip, and one that read the count live would end the walk early. It uses a short period with four chips so that an expiry lands mid-walk, and another case so that an expiry lands exactly on the final handshake. A design that compared against the wrong busy condition would either start overlapping walks or flag overrun where none occurred. It also changes the period mid-interval, which a design that reloads on every write would get wrong.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Width of a chip index for a given number of chip selects.
  function automatic int unsigned chip_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rfsh_chip_mask.sv
module rfsh_chip_mask #(
  parameter int CHIPS  = 4,
  parameter int CHIP_W = 2
) (
  input  logic [CHIP_W-1:0] active,
  output logic [CHIPS-1:0]  mask
);

  // Chips 0..active are populated; higher selects are masked off first.
  for (genvar g = 0; g < CHIPS; g++) begin : g_bit
    assign mask[g] = (int'(active) >= g);
  end

endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [PERIOD_W-1:0] period,
  output logic                tick
);

  logic [PERIOD_W-1:0] cnt_q;
  logic                run;

  assign run = en && (period != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (!run) begin
      cnt_q <= period - PERIOD_W'(1);
      tick  <= 1'b0;
    end else if (cnt_q == '0) begin
      cnt_q <= period - PERIOD_W'(1);
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q - PERIOD_W'(1);
      tick  <= 1'b0;
    end
  end

  // R5 / R6: a stopped timer never expires on the next edge.
  assert_stopped_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !run |=> !tick);

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq #(
  parameter int CHIPS  = 4,
  parameter int CHIP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tick,
  input  logic [CHIPS-1:0]  mask_in,
  input  logic              ready,
  output logic              valid,
  output logic [CHIP_W-1:0] chip,
  output logic              overrun
);

  logic [CHIPS-1:0]  mask_q;
  logic [CHIP_W-1:0] first_idx;
  logic [CHIP_W-1:0] next_idx;
  logic              has_next;
  logic              finish;
  logic              busy;

  // Lowest enabled chip of the incoming mask, and the next enabled chip
  // above the current one in the captured mask.
  always_comb begin
    first_idx = '0;
    next_idx  = chip;
    has_next  = 1'b0;
    for (int i = CHIPS - 1; i >= 0; i--) begin
      if (mask_in[i]) first_idx = CHIP_W'(i);
      if (mask_q[i] && (i > int'(chip))) begin
        next_idx = CHIP_W'(i);
        has_next = 1'b1;
      end
    end
  end

  assign finish = valid && ready && !has_next;
  assign busy   = valid && !finish;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid   <= 1'b0;
      chip    <= '0;
      overrun <= 1'b0;
      mask_q  <= '0;
    end else if (!en) begin
      valid <= 1'b0;
    end else begin
      if (tick && busy) overrun <= 1'b1;
      if (tick && !busy && (mask_in != '0)) begin
        valid  <= 1'b1;
        chip   <= first_idx;
        mask_q <= mask_in;
      end else if (valid && ready) begin
        if (has_next) chip <= next_idx;
        else          valid <= 1'b0;
      end
    end
  end

  // R4: a stalled request holds.
  assert_hold_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready && en) |=> (valid && $stable(chip)));

  // R6: disable clears the request.
  assert_disable_drops_R6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !valid);

  // R2: a walk starts only after an expiry.
  assert_start_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $past(tick));

  // R8: overrun only from an expiry during a pending walk.
  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(tick && valid));

  // R8: overrun is sticky.
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R3: the presented chip is one of the captured populated chips.
  assert_chip_enabled_R3: assert property (@(posedge clk) disable iff (rst)
    valid |-> mask_q[chip]);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int CHIPS    = 4,
  parameter int PERIOD_W = 16,
  localparam int CHIP_W  = chip_bits(CHIPS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                refresh_en,
  input  logic [PERIOD_W-1:0] period,
  input  logic [CHIP_W-1:0]   active_chips,
  output logic                req_valid,
  output logic [CHIP_W-1:0]   req_chip,
  input  logic                req_ready,
  output logic                overrun
);

  logic [CHIPS-1:0] chip_mask;
  logic             expire;

  rfsh_chip_mask #(.CHIPS(CHIPS), .CHIP_W(CHIP_W)) u_mask (
    .active (active_chips),
    .mask   (chip_mask)
  );

  rfsh_timer #(.PERIOD_W(PERIOD_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .en     (refresh_en),
    .period (period),
    .tick   (expire)
  );

  rfsh_seq #(.CHIPS(CHIPS), .CHIP_W(CHIP_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .en      (refresh_en),
    .tick    (expire),
    .mask_in (chip_mask),
    .ready   (req_ready),
    .valid   (req_valid),
    .chip    (req_chip),
    .overrun (overrun)
  );

  // R1: reset leaves nothing pending.
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!req_valid && !overrun));

endmodule

// File: tb/rfsh_sched_test.sv
module rfsh_sched_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        refresh_en;
  logic [15:0] period;
  logic [1:0]  active_chips;
  logic        req_valid;
  logic [1:0]  req_chip;
  logic        req_ready;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rfsh_sched uut (
    .clk          (clk),
    .rst          (rst),
    .refresh_en   (refresh_en),
    .period       (period),
    .active_chips (active_chips),
    .req_valid    (req_valid),
    .req_chip     (req_chip),
    .req_ready    (req_ready),
    .overrun      (overrun)
  );

  localparam int NV = 5;
  localparam int VP [NV] = '{5, 3, 8, 6, 2};
  localparam int VN [NV] = '{3, 0, 1, 2, 3};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input int p, input int n);
    @(negedge clk);
    rst = 1'b1; refresh_en = 1'b0; req_ready = 1'b1;
    period = 16'(p); active_chips = 2'(n);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int early;
    do_reset(5, 3);
    // R1
    check(!req_valid && !overrun && req_chip == 0, "R1", int'(req_valid), 0);

    // Table-driven walks
    for (int v = 0; v < NV; v++) begin
      int p = VP[v];
      int n = VN[v];
      do_reset(p, n);
      refresh_en = 1'b1;
      early = 0;
      for (int e = 1; e <= p; e++) begin
        edge_sample();
        if (req_valid) early++;
      end
      check(early == 0, "R2 no early request", early, 0);
      edge_sample();
      check(req_valid == 1'b1, "R2 first request edge", int'(req_valid), 1);
      for (int k = 0; k <= n; k++) begin
        check(req_valid && req_chip == 2'(k), "R3 chip order", int'(req_chip), k);
        edge_sample();
      end
      if (p > n + 1)
        check(!req_valid, "R3 walk ends", int'(req_valid), 0);
      repeat (2 * p - n) edge_sample();
      check(overrun == (p <= n), "R8 overrun", int'(overrun), int'(p <= n));
    end

    // R4 stall, R9 count captured, R8 expiry on final handshake
    do_reset(6, 2);
    req_ready = 1'b0;
    refresh_en = 1'b1;
    repeat (7) edge_sample();
    check(req_valid && req_chip == 0, "R4 first", int'(req_chip), 0);
    @(negedge clk);
    active_chips = 2'd0;
    for (int s = 0; s < 3; s++) begin
      edge_sample();
      check(req_valid && req_chip == 0, "R4 hold", int'(req_chip), 0);
    end
    @(negedge clk);
    req_ready = 1'b1;
    edge_sample();
    check(req_valid && req_chip == 1, "R9 chip1", int'(req_chip), 1);
    edge_sample();
    check(req_valid && req_chip == 2, "R9 chip2", int'(req_chip), 2);
    edge_sample();
    check(req_valid && req_chip == 0, "R8 back-to-back start", int'(req_valid), 1);
    check(!overrun, "R8 no overrun on final handshake", int'(overrun), 0);
    edge_sample();
    check(!req_valid, "R9 new count applies", int'(req_valid), 0);

    // R7 period change mid-interval
    do_reset(4, 0);
    refresh_en = 1'b1;
    repeat (5) edge_sample();
    check(req_valid, "R7 first", int'(req_valid), 1);
    @(negedge clk);
    period = 16'd10;
    for (int e = 6; e <= 19; e++) begin
      edge_sample();
      check(req_valid == (e == 9 || e == 19), "R7 interval", int'(req_valid),
            int'(e == 9 || e == 19));
    end

    // R5 period zero
    do_reset(0, 3);
    refresh_en = 1'b1;
    early = 0;
    for (int e = 0; e < 30; e++) begin
      edge_sample();
      if (req_valid) early++;
    end
    check(early == 0, "R5 zero period", early, 0);

    // R6 enable low
    do_reset(3, 3);
    req_ready = 1'b0;
    early = 0;
    for (int e = 0; e < 30; e++) begin
      edge_sample();
      if (req_valid) early++;
    end
    check(early == 0, "R6 disabled", early, 0);
    @(negedge clk);
    refresh_en = 1'b1;
    repeat (4) edge_sample();
    check(req_valid, "R6 enabled request", int'(req_valid), 1);
    @(negedge clk);
    refresh_en = 1'b0;
    edge_sample();
    check(!req_valid, "R6 drop", int'(req_valid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule